// File: doc/BRIEF.md
# LPC Target SYNC Wait-State Responder

This block runs the response phase of a target on the LPC bus. The surrounding target logic decodes the cycle and completes the host turnaround. It then pulses `start` together with the cycle kind: I/O or DMA, the data direction, and whether more DMA data is pending. From the next clock on, the block owns LAD[3:0]. While the internal backend is not ready, it drives a wait-state SYNC nibble. Once `be_ready` is seen, it drives a ready SYNC nibble in that same clock. For a read it follows at once with the data byte, sent as nibbles with the low one first. Every cycle closes with one clock of 4'b1111 before the bus is released.

The wait nibble is chosen once per cycle from the cycle kind and never changes until ready. DMA cycles always wait with the short-wait code. I/O cycles always wait with the long-wait code. A DMA transfer moves exactly one byte.

An abort from the surrounding logic takes the block off the bus in the same clock. The abort is then reported by a one-clock flag, and no completion is signalled.

Top module: `lpc_sync_responder`

## Requirements
- R1: During and right after reset, `lad_oe`, `done` and `aborted` are 0 and `lad_out` is 4'b1111.
- R2: In the clock after a `start` pulse taken while idle, `lad_oe` is 1 and a SYNC nibble is on `lad_out`. This is well inside the 3-clock limit.
- R3: Each clock the wait nibble is on the bus, it equals the wait nibble of the clock before, until the ready nibble appears.
- R4: The wait nibble is 4'b0101 when `is_dma`=1 was latched at `start`, and 4'b0110 when `is_dma`=0.
- R5: The ready nibble is 4'b1001 when both `is_dma` and `more_pending` were 1 at `start`; otherwise it is 4'b0000.
- R6: In a read (`is_read`=1), `rd_data` is sampled in the ready clock. Bits [3:0] are driven in the next clock and bits [7:4] in the clock after, with no gap.
- R7: After the last data nibble of a read, or after the ready nibble of a write, one clock drives 4'b1111 with `lad_oe`=1 and `done`=1. In the following clock `lad_oe` and `done` are 0.
- R8: `abort` while a cycle is active drops `lad_oe` in that same clock. The block returns to idle, `aborted` is 1 for exactly the next clock, and `done` does not rise for that cycle.
- R9: If `be_ready` is 1 in the first SYNC clock, the ready nibble is driven there with no wait nibble before it.
- R10: A `start` pulse while a cycle is active is ignored. The wait code and the sequence of the running cycle are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-clock pulse: sync phase opens for a decoded cycle |
| is_dma | input | 1 | Cycle kind at start: 1 DMA, 0 I/O |
| is_read | input | 1 | 1 when the target returns data to the host |
| more_pending | input | 1 | DMA only: more data pending after this byte |
| be_ready | input | 1 | Backend ready; ends the wait phase |
| rd_data | input | 8 | Read byte, sampled in the ready clock |
| abort | input | 1 | Abandon the active cycle |
| lad_out | output | 4 | Nibble driven on LAD[3:0] |
| lad_oe | output | 1 | LAD output enable |
| done | output | 1 | High in the closing turnaround clock |
| aborted | output | 1 | One-clock pulse after an abort |

## Verification
A table of transfers varies cycle kind, direction, pending flag, wait count and data byte. DMA and I/O rows tell the two wait codes apart. Rows with and without the pending flag separate the two ready codes. Rows with zero, one and many waits show that the code holds steady and that the ready clock sits at the right place. Reads and writes with distinct bytes expose nibble order and any gap before the turnaround. Directed runs then check reset, an abort in the middle of the wait phase and one in the middle of the data, and a stray `start` during waits that carries the opposite cycle kind.

// File: rtl/lpc_sync_pkg.sv
package lpc_sync_pkg;

    localparam int NIB_W = 4;

    localparam logic [NIB_W-1:0] SYNC_SHORT_WAIT = 4'b0101;
    localparam logic [NIB_W-1:0] SYNC_LONG_WAIT  = 4'b0110;
    localparam logic [NIB_W-1:0] SYNC_READY      = 4'b0000;
    localparam logic [NIB_W-1:0] SYNC_READY_MORE = 4'b1001;
    localparam logic [NIB_W-1:0] NIB_TURN        = 4'b1111;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SYNC,
        PH_DATA,
        PH_TURN
    } phase_e;

    typedef struct packed {
        logic dma;
        logic rd;
        logic more;
    } cyc_t;

    function automatic logic [NIB_W-1:0] wait_code(input cyc_t c);
        return c.dma ? SYNC_SHORT_WAIT : SYNC_LONG_WAIT;
    endfunction

    function automatic logic [NIB_W-1:0] ready_code(input cyc_t c);
        return (c.dma && c.more) ? SYNC_READY_MORE : SYNC_READY;
    endfunction

endpackage

// File: rtl/lpc_sync_ctrl.sv
module lpc_sync_ctrl
    import lpc_sync_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int NIBBLES = DATA_W / NIB_W,
    parameter int IDX_W   = (NIBBLES > 1) ? $clog2(NIBBLES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              is_dma,
    input  logic              is_read,
    input  logic              more_pending,
    input  logic              be_ready,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              abort,
    output phase_e            phase,
    output cyc_t              cyc,
    output logic [IDX_W-1:0]  nib_idx,
    output logic [DATA_W-1:0] data_q,
    output logic              done,
    output logic              aborted
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NIBBLES - 1);

    logic active;
    assign active = (phase != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cyc     <= '0;
            nib_idx <= '0;
            data_q  <= '0;
            aborted <= 1'b0;
        end else begin
            aborted <= 1'b0;
            if (active && abort) begin
                phase   <= PH_IDLE;
                aborted <= 1'b1;
            end else begin
                case (phase)
                    PH_IDLE: begin
                        if (start) begin
                            cyc   <= '{dma: is_dma, rd: is_read, more: more_pending};
                            phase <= PH_SYNC;
                        end
                    end
                    PH_SYNC: begin
                        if (be_ready) begin
                            data_q  <= rd_data;
                            nib_idx <= '0;
                            phase   <= cyc.rd ? PH_DATA : PH_TURN;
                        end
                    end
                    PH_DATA: begin
                        if (nib_idx == LAST_IDX) begin
                            phase <= PH_TURN;
                        end else begin
                            nib_idx <= nib_idx + 1'b1;
                        end
                    end
                    PH_TURN: phase <= PH_IDLE;
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    assign done = (phase == PH_TURN) && !abort;

    AST_START_OPENS_SYNC: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && start) |=> (phase == PH_SYNC)); // R2

    AST_ABORT_IDLES: assert property (@(posedge clk) disable iff (rst)
        aborted |-> (phase == PH_IDLE && !done)); // R8

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (active && start && !abort) |=> (cyc == $past(cyc))); // R10

endmodule

// File: rtl/lpc_sync_nibble_mux.sv
module lpc_sync_nibble_mux
    import lpc_sync_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int NIBBLES = DATA_W / NIB_W,
    parameter int IDX_W   = (NIBBLES > 1) ? $clog2(NIBBLES) : 1
) (
    input  phase_e            phase,
    input  cyc_t              cyc,
    input  logic              be_ready,
    input  logic [IDX_W-1:0]  nib_idx,
    input  logic [DATA_W-1:0] data_q,
    output logic [NIB_W-1:0]  nib,
    output logic              drive
);

    logic [NIB_W-1:0] data_nibs [NIBBLES];

    for (genvar g = 0; g < NIBBLES; g++) begin : g_split
        assign data_nibs[g] = data_q[g*NIB_W +: NIB_W];
    end

    always_comb begin
        drive = (phase != PH_IDLE);
        case (phase)
            PH_SYNC: nib = be_ready ? ready_code(cyc) : wait_code(cyc);
            PH_DATA: nib = data_nibs[nib_idx];
            default: nib = NIB_TURN;
        endcase
    end

endmodule

// File: rtl/lpc_sync_responder.sv
module lpc_sync_responder
    import lpc_sync_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              is_dma,
    input  logic              is_read,
    input  logic              more_pending,
    input  logic              be_ready,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              abort,
    output logic [3:0]        lad_out,
    output logic              lad_oe,
    output logic              done,
    output logic              aborted
);

    localparam int NIBBLES = DATA_W / NIB_W;
    localparam int IDX_W   = (NIBBLES > 1) ? $clog2(NIBBLES) : 1;

    phase_e            phase;
    cyc_t              cyc;
    logic [IDX_W-1:0]  nib_idx;
    logic [DATA_W-1:0] data_q;
    logic              drive;

    lpc_sync_ctrl #(.DATA_W(DATA_W), .NIBBLES(NIBBLES), .IDX_W(IDX_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .is_dma       (is_dma),
        .is_read      (is_read),
        .more_pending (more_pending),
        .be_ready     (be_ready),
        .rd_data      (rd_data),
        .abort        (abort),
        .phase        (phase),
        .cyc          (cyc),
        .nib_idx      (nib_idx),
        .data_q       (data_q),
        .done         (done),
        .aborted      (aborted)
    );

    lpc_sync_nibble_mux #(.DATA_W(DATA_W), .NIBBLES(NIBBLES), .IDX_W(IDX_W)) u_mux (
        .phase    (phase),
        .cyc      (cyc),
        .be_ready (be_ready),
        .nib_idx  (nib_idx),
        .data_q   (data_q),
        .nib      (lad_out),
        .drive    (drive)
    );

    assign lad_oe = drive && !abort;

    logic in_wait;
    assign in_wait = (phase == PH_SYNC) && !be_ready;

    AST_WAIT_HELD: assert property (@(posedge clk) disable iff (rst)
        (in_wait && !abort) |=> (in_wait -> lad_out == $past(lad_out))); // R3

    AST_LOW_NIBBLE_NEXT: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SYNC && be_ready && cyc.rd && !abort)
        |=> (abort || (lad_oe && lad_out == $past(rd_data[3:0])))); // R6

    AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (abort && phase != PH_IDLE) |-> !lad_oe); // R8

    AST_TURN_RELEASES: assert property (@(posedge clk) disable iff (rst)
        done |=> (!lad_oe && !done)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> (!lad_oe && !done && lad_out == NIB_TURN)); // R1

endmodule

// File: tb/sim_lpc_sync_responder.sv
module sim_lpc_sync_responder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0, is_dma = 1'b0, is_read = 1'b0, more_pending = 1'b0;
    logic       be_ready = 1'b0, abort = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic [3:0] lad_out;
    logic       lad_oe, done, aborted;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    lpc_sync_responder u0 (
        .clk(clk), .rst(rst), .start(start), .is_dma(is_dma), .is_read(is_read),
        .more_pending(more_pending), .be_ready(be_ready), .rd_data(rd_data),
        .abort(abort), .lad_out(lad_out), .lad_oe(lad_oe), .done(done), .aborted(aborted)
    );

    typedef struct packed {
        logic       dma;
        logic       rd;
        logic       more;
        logic [3:0] waits;
        logic [7:0] data;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        {1'b1, 1'b1, 1'b0, 4'd0, 8'hA5},
        {1'b0, 1'b1, 1'b0, 4'd3, 8'h3C},
        {1'b1, 1'b1, 1'b1, 4'd1, 8'h96},
        {1'b0, 1'b0, 1'b1, 4'd2, 8'h00},
        {1'b1, 1'b0, 1'b1, 4'd0, 8'hFF},
        {1'b0, 1'b1, 1'b1, 4'd0, 8'h71},
        {1'b1, 1'b0, 1'b0, 4'd6, 8'h00},
        {1'b0, 1'b0, 1'b0, 4'd1, 8'h00}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_wait(input logic dma);
        return dma ? 4'b0101 : 4'b0110;
    endfunction

    function automatic logic [3:0] exp_ready(input logic dma, input logic more);
        return (dma && more) ? 4'b1001 : 4'b0000;
    endfunction

    task automatic run_xfer(input vec_t v, input bit poke);
        @(negedge clk);
        start = 1'b1; is_dma = v.dma; is_read = v.rd; more_pending = v.more;
        be_ready = 1'b0; rd_data = v.data;
        for (int i = 0; i <= int'(v.waits); i++) begin
            @(negedge clk);
            start = poke && (i == 1);
            if (poke && i == 1) begin
                is_dma = ~v.dma; more_pending = ~v.more;
            end
            be_ready = (i == int'(v.waits));
            #1;
            if (i == 0) chk("R2 oe in first SYNC clock", {7'd0, lad_oe}, 8'd1);
            if (i == int'(v.waits)) begin
                if (v.waits == 0)
                    chk("R9 zero-wait ready", {4'd0, lad_out}, {4'd0, exp_ready(v.dma, v.more)});
                else
                    chk("R5 ready code", {4'd0, lad_out}, {4'd0, exp_ready(v.dma, v.more)});
            end else if (poke && i >= 1) begin
                chk("R10 start ignored mid-cycle", {4'd0, lad_out}, {4'd0, exp_wait(v.dma)});
            end else if (i > 0) begin
                chk("R3 wait held", {4'd0, lad_out}, {4'd0, exp_wait(v.dma)});
            end else begin
                chk("R4 wait code", {4'd0, lad_out}, {4'd0, exp_wait(v.dma)});
            end
        end
        start = 1'b0; is_dma = v.dma; more_pending = v.more;
        if (v.rd) begin
            @(negedge clk); be_ready = 1'b0; rd_data = 8'h00; #1;
            chk("R6 low nibble", {3'd0, lad_oe, lad_out}, {4'd1, v.data[3:0]});
            @(negedge clk); #1;
            chk("R6 high nibble", {3'd0, lad_oe, lad_out}, {4'd1, v.data[7:4]});
        end
        @(negedge clk); be_ready = 1'b0; #1;
        chk("R7 turnaround", {2'd0, lad_oe, done, lad_out}, {2'd0, 1'b1, 1'b1, 4'hF});
        @(negedge clk); #1;
        chk("R7 release", {6'd0, lad_oe, done}, 8'd0);
    endtask

    initial begin
        #(5 * 20000);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset outputs", {1'b0, lad_oe, done, aborted, lad_out}, {4'd0, 4'hF});
        @(negedge clk); rst = 1'b0; #1;
        chk("R1 after reset", {1'b0, lad_oe, done, aborted, lad_out}, {4'd0, 4'hF});

        for (int k = 0; k < NVEC; k++) run_xfer(VECS[k], 1'b0);

        run_xfer('{dma: 1'b0, rd: 1'b1, more: 1'b0, waits: 4'd4, data: 8'h5A}, 1'b1);
        run_xfer('{dma: 1'b1, rd: 1'b0, more: 1'b1, waits: 4'd3, data: 8'h00}, 1'b1);

        // R8: abort during waits
        @(negedge clk); start = 1'b1; is_dma = 1'b1; is_read = 1'b1; more_pending = 1'b0;
        @(negedge clk); start = 1'b0;
        @(negedge clk); abort = 1'b1; #1;
        chk("R8 oe drops at once", {7'd0, lad_oe}, 8'd0);
        @(negedge clk); abort = 1'b0; #1;
        chk("R8 abort flag", {5'd0, aborted, done, lad_oe}, 8'b100);
        @(negedge clk); #1;
        chk("R8 flag one clock", {5'd0, aborted, done, lad_oe}, 8'd0);

        // R8: abort during data
        @(negedge clk); start = 1'b1; is_dma = 1'b0; is_read = 1'b1; rd_data = 8'hC3;
        @(negedge clk); start = 1'b0; be_ready = 1'b1;
        @(negedge clk); be_ready = 1'b0; #1;
        chk("R6 low nibble before abort", {4'd0, lad_out}, 8'h03);
        @(negedge clk); abort = 1'b1; #1;
        chk("R8 oe drops in data", {7'd0, lad_oe}, 8'd0);
        for (int j = 0; j < 3; j++) begin
            @(negedge clk); abort = 1'b0; #1;
            chk("R8 no done after abort", {6'd0, done, lad_oe}, 8'd0);
        end

        // R8: abort while idle has no effect
        @(negedge clk); abort = 1'b1;
        @(negedge clk); abort = 1'b0; #1;
        chk("R8 idle abort ignored", {6'd0, aborted, lad_oe}, 8'd0);

        run_xfer(VECS[1], 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule